// File: doc/BRIEF.md
# Single-wire debug transaction parser

This block sits behind the frame receiver of a single-wire debug link. Each frame the receiver accepts is handed over as a payload byte, a direction flag taken from its start bit, and an acknowledge flag. The parser walks the fixed shape of a debug transaction. A command frame comes first, then a byte-count frame, then the address bytes from the most significant down, and then the data bytes. It reports each step on its own valid strobe. The number of data frames is set by the count byte that arrived on the wire.

The receiver needs to know how long the next frame is, because a command frame is shorter than a byte frame. The parser tells it through `expect_data_o`. A synchronisation low seen by the receiver is passed in as `sync_rst_i` and drops any transaction in progress. All reports are registered and appear one clock after the frame that caused them.

Top module: `dbg_txn_parser`

## Requirements
- R1: After reset, or after a reset in the middle of a transaction, `expect_data_o` is 0 and the three valid strobes are 0.
- R2: A frame with `frm_ack_i` = 0 causes no report and does not move the parser. This holds for every phase, including the data phase, where it does not use up the remaining count.
- R3: In the command phase an acknowledged byte of 0x00 (system reset) is reported with `cmd_valid_o` = 1 and `cmd_unknown_o` = 0, and the parser stays in the command phase.
- R4: Command 0x01 (read) and command 0x02 (write) are reported and move the parser to the count phase, so `expect_data_o` reads 1 in the next cycle.
- R5: Any other command byte is reported with `cmd_unknown_o` = 1, and the parser stays in the command phase.
- R6: The first acknowledged byte after a read or write command is stored as the transfer count and produces no report.
- R7: The next three acknowledged bytes are shifted in most significant first to make a 24-bit address. `addr_valid_o` pulses once with that address, one cycle after the third byte.
- R8: Each acknowledged frame in the data phase is reported one cycle later on `dat_byte_o`, with its direction on `dat_dir_o` and a one-cycle `dat_valid_o`. At most one of the three strobes is high in any cycle.
- R9: A count of N ≥ 1 yields exactly N data reports. After the last one the parser is back in the command phase.
- R10: A count of 0 yields one data report, and then the parser returns to the command phase.
- R11: `sync_rst_i` returns the parser to the command phase in the next cycle. It wins over a frame in the same cycle, and that frame is discarded without a report.
- R12: `expect_data_o` is 0 in the command phase and 1 in the count, address and data phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_valid_i | input | 1 | One-cycle strobe: a frame has been received |
| frm_byte_i | input | 8 | Frame payload (the command code in the command phase) |
| frm_dir_i | input | 1 | Direction from the start bit (1 = target to host) |
| frm_ack_i | input | 1 | Frame was acknowledged |
| sync_rst_i | input | 1 | Synchronisation frame seen; aborts the transaction |
| expect_data_o | output | 1 | 1 = next frame is a byte frame, 0 = a command frame |
| cmd_valid_o | output | 1 | Command report strobe |
| cmd_code_o | output | 8 | Reported command code |
| cmd_unknown_o | output | 1 | Reported command is not a known code |
| addr_valid_o | output | 1 | Address report strobe |
| addr_o | output | 24 | Assembled address |
| dat_valid_o | output | 1 | Data report strobe |
| dat_byte_o | output | 8 | Reported data byte |
| dat_dir_o | output | 1 | Direction of the reported data byte |

## Verification
The bench goes after four corner cases.

A count of zero is the first. A design that decrements before it tests the count would wrap to 255 and stay in the data phase.

A rejected frame in the middle of the address and data phases is the second. A design that ignores the acknowledge flag would shift a wrong byte into the address, or end the transfer one byte early.

A synchronisation frame that arrives together with a valid frame is the third. A design that gives the frame priority would report a phantom count or command, and leave `expect_data_o` high.

The address byte order is the fourth. A byte-reversed or misaligned shifter shows up as a wrong `addr_o`.

// File: rtl/dbg_txn_pkg.sv
package dbg_txn_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {PH_CMD, PH_COUNT, PH_ADDR, PH_DATA} phase_e;

  // True when the code opens a transfer that carries count, address and data.
  function automatic logic is_xfer_code(input logic [BYTE_W-1:0] code,
                                        input logic [BYTE_W-1:0] rd_code,
                                        input logic [BYTE_W-1:0] wr_code);
    return (code == rd_code) || (code == wr_code);
  endfunction

  function automatic logic is_known_code(input logic [BYTE_W-1:0] code,
                                         input logic [BYTE_W-1:0] srst_code,
                                         input logic [BYTE_W-1:0] rd_code,
                                         input logic [BYTE_W-1:0] wr_code);
    return (code == srst_code) || is_xfer_code(code, rd_code, wr_code);
  endfunction

  // Remaining count after one data byte: saturates at zero.
  function automatic logic [BYTE_W-1:0] count_after(input logic [BYTE_W-1:0] rem);
    return (rem == '0) ? '0 : rem - 1'b1;
  endfunction

  // The data byte that closes the transfer: count 1, or the single byte of count 0.
  function automatic logic is_final_data(input logic [BYTE_W-1:0] rem);
    return rem <= BYTE_W'(1);
  endfunction
endpackage

// File: rtl/dbg_txn_fsm.sv
module dbg_txn_fsm
  import dbg_txn_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter logic [BYTE_W-1:0] CODE_SRST = 8'h00,
  parameter logic [BYTE_W-1:0] CODE_RD   = 8'h01,
  parameter logic [BYTE_W-1:0] CODE_WR   = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid_i,
  input  logic              frm_ack_i,
  input  logic              sync_rst_i,
  input  logic [BYTE_W-1:0] frm_byte_i,
  output phase_e            phase_o,
  output logic              ev_cmd_o,
  output logic              ev_addr_byte_o,
  output logic              ev_addr_last_o,
  output logic              ev_data_o,
  output logic              ev_data_last_o
);
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

  phase_e            phase_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] remain_q;

  logic take;
  logic ev_count;

  assign take           = frm_valid_i & frm_ack_i & ~sync_rst_i;
  assign ev_cmd_o       = take & (phase_q == PH_CMD);
  assign ev_count       = take & (phase_q == PH_COUNT);
  assign ev_addr_byte_o = take & (phase_q == PH_ADDR);
  assign ev_addr_last_o = ev_addr_byte_o & (idx_q == LAST_IDX);
  assign ev_data_o      = take & (phase_q == PH_DATA);
  assign ev_data_last_o = ev_data_o & is_final_data(remain_q);
  assign phase_o        = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_CMD;
      idx_q    <= '0;
      remain_q <= '0;
    end else if (sync_rst_i) begin
      phase_q  <= PH_CMD;
      idx_q    <= '0;
      remain_q <= '0;
    end else begin
      if (ev_cmd_o && is_xfer_code(frm_byte_i, CODE_RD, CODE_WR)) begin
        phase_q <= PH_COUNT;
      end
      if (ev_count) begin
        remain_q <= frm_byte_i;
        idx_q    <= '0;
        phase_q  <= PH_ADDR;
      end
      if (ev_addr_byte_o) begin
        idx_q <= idx_q + 1'b1;
        if (ev_addr_last_o) begin
          phase_q <= PH_DATA;
        end
      end
      if (ev_data_o) begin
        remain_q <= count_after(remain_q);
        if (ev_data_last_o) begin
          phase_q <= PH_CMD;
        end
      end
    end
  end

  // R4
  xfer_cmd_enters_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_o && is_xfer_code(frm_byte_i, CODE_RD, CODE_WR)) |=> (phase_q == PH_COUNT));

  // R7
  addr_last_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_last_o |=> (phase_q == PH_DATA));

  // R9
  data_last_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_last_o |=> (phase_q == PH_CMD));

  // R11
  sync_clears_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rst_i |=> (phase_q == PH_CMD));
endmodule

// File: rtl/dbg_txn_addr.sv
module dbg_txn_addr
  import dbg_txn_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  localparam int ADDR_W = ADDR_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] frm_byte_i,
  input  logic              ev_addr_byte_i,
  input  logic              ev_addr_last_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_valid_o
);
  logic [ADDR_W-1:0]        acc_q;
  logic [ADDR_W+BYTE_W-1:0] widened;
  logic [ADDR_W-1:0]        shifted;

  // Oldest byte ends up most significant.
  assign widened = {acc_q, frm_byte_i};
  assign shifted = widened[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q        <= '0;
      addr_o       <= '0;
      addr_valid_o <= 1'b0;
    end else begin
      addr_valid_o <= ev_addr_last_i;
      if (ev_addr_byte_i) begin
        acc_q <= shifted;
      end
      if (ev_addr_last_i) begin
        addr_o <= shifted;
      end
    end
  end

  // R7
  addr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o |=> !addr_valid_o);
endmodule

// File: rtl/dbg_txn_parser.sv
module dbg_txn_parser
  import dbg_txn_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter logic [BYTE_W-1:0] CODE_SRST = 8'h00,
  parameter logic [BYTE_W-1:0] CODE_RD   = 8'h01,
  parameter logic [BYTE_W-1:0] CODE_WR   = 8'h02,
  localparam int ADDR_W = ADDR_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid_i,
  input  logic [BYTE_W-1:0] frm_byte_i,
  input  logic              frm_dir_i,
  input  logic              frm_ack_i,
  input  logic              sync_rst_i,
  output logic              expect_data_o,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] cmd_code_o,
  output logic              cmd_unknown_o,
  output logic              addr_valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dat_valid_o,
  output logic [BYTE_W-1:0] dat_byte_o,
  output logic              dat_dir_o
);
  phase_e phase;
  logic   ev_cmd, ev_addr_byte, ev_addr_last, ev_data, ev_data_last;

  dbg_txn_fsm #(
    .ADDR_BYTES(ADDR_BYTES), .CODE_SRST(CODE_SRST),
    .CODE_RD(CODE_RD), .CODE_WR(CODE_WR)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .frm_valid_i(frm_valid_i), .frm_ack_i(frm_ack_i),
    .sync_rst_i(sync_rst_i), .frm_byte_i(frm_byte_i), .phase_o(phase),
    .ev_cmd_o(ev_cmd), .ev_addr_byte_o(ev_addr_byte), .ev_addr_last_o(ev_addr_last),
    .ev_data_o(ev_data), .ev_data_last_o(ev_data_last)
  );

  dbg_txn_addr #(.ADDR_BYTES(ADDR_BYTES)) addr_i (
    .clk(clk), .rst_n(rst_n), .frm_byte_i(frm_byte_i),
    .ev_addr_byte_i(ev_addr_byte), .ev_addr_last_i(ev_addr_last),
    .addr_o(addr_o), .addr_valid_o(addr_valid_o)
  );

  assign expect_data_o = (phase != PH_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_o   <= 1'b0;
      cmd_code_o    <= '0;
      cmd_unknown_o <= 1'b0;
      dat_valid_o   <= 1'b0;
      dat_byte_o    <= '0;
      dat_dir_o     <= 1'b0;
    end else begin
      cmd_valid_o   <= ev_cmd;
      cmd_unknown_o <= ev_cmd & ~is_known_code(frm_byte_i, CODE_SRST, CODE_RD, CODE_WR);
      dat_valid_o   <= ev_data;
      if (ev_cmd) begin
        cmd_code_o <= frm_byte_i;
      end
      if (ev_data) begin
        dat_byte_o <= frm_byte_i;
        dat_dir_o  <= frm_dir_i;
      end
    end
  end

  // R2
  nack_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid_i && !frm_ack_i && !sync_rst_i)
      |=> (!cmd_valid_o && !addr_valid_o && !dat_valid_o && $stable(expect_data_o)));

  // R3 R5
  nonxfer_cmd_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !is_xfer_code(cmd_code_o, CODE_RD, CODE_WR)) |-> !expect_data_o);

  // R8
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid_o, addr_valid_o, dat_valid_o}));

  // R11
  sync_no_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rst_i |=> (!cmd_valid_o && !addr_valid_o && !dat_valid_o && !expect_data_o));

  // R12
  data_only_when_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid_o |-> $past(expect_data_o));
endmodule

// File: tb/dbg_txn_parser_tb.sv
module dbg_txn_parser_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid_i = 1'b0;
  logic [7:0]  frm_byte_i = '0;
  logic        frm_dir_i = 1'b0;
  logic        frm_ack_i = 1'b0;
  logic        sync_rst_i = 1'b0;
  logic        expect_data_o, cmd_valid_o, cmd_unknown_o, addr_valid_o, dat_valid_o, dat_dir_o;
  logic [7:0]  cmd_code_o, dat_byte_o;
  logic [23:0] addr_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dbg_txn_parser dut_i (
    .clk(clk), .rst_n(rst_n), .frm_valid_i(frm_valid_i), .frm_byte_i(frm_byte_i),
    .frm_dir_i(frm_dir_i), .frm_ack_i(frm_ack_i), .sync_rst_i(sync_rst_i),
    .expect_data_o(expect_data_o), .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o),
    .cmd_unknown_o(cmd_unknown_o), .addr_valid_o(addr_valid_o), .addr_o(addr_o),
    .dat_valid_o(dat_valid_o), .dat_byte_o(dat_byte_o), .dat_dir_o(dat_dir_o)
  );

  typedef struct packed {
    logic       sy; logic v; logic ak; logic dr; logic [7:0] b;
    logic       ecv; logic [7:0] ecc; logic eunk;
    logic       eav; logic [23:0] ea;
    logic       edv; logic [7:0] edb; logic edd;
    logic       eexp;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 29;
  // Fields: sync valid ack dir byte | cmd_v code unk | addr_v addr | dat_v byte dir | expect | req
  localparam vec_t VEC [NV] = '{
    '{0,0,0,0,8'h00, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 0, 1},   // R1 idle
    '{0,1,1,0,8'h00, 1,8'h00,0, 0,24'h0, 0,8'h00,0, 0, 3},   // R3 system reset
    '{0,1,1,0,8'h05, 1,8'h05,1, 0,24'h0, 0,8'h00,0, 0, 5},   // R5 unknown
    '{0,1,0,0,8'h02, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 0, 2},   // R2 nacked command
    '{0,1,1,0,8'h02, 1,8'h02,0, 0,24'h0, 0,8'h00,0, 1, 4},   // R4 write
    '{0,1,1,0,8'h03, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 1, 6},   // R6 count 3
    '{0,1,0,0,8'h77, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 1, 2},   // R2 nack in address phase
    '{0,1,1,0,8'h12, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 1, 7},
    '{0,1,1,0,8'h34, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 1, 7},
    '{0,1,1,0,8'h56, 0,8'h00,0, 1,24'h123456, 0,8'h00,0, 1, 7}, // R7
    '{0,1,1,1,8'hA1, 0,8'h00,0, 0,24'h0, 1,8'hA1,1, 1, 8},   // R8
    '{0,1,1,0,8'hA2, 0,8'h00,0, 0,24'h0, 1,8'hA2,0, 1, 8},
    '{0,1,1,1,8'hA3, 0,8'h00,0, 0,24'h0, 1,8'hA3,1, 0, 9},   // R9 third of three
    '{0,1,1,0,8'h01, 1,8'h01,0, 0,24'h0, 0,8'h00,0, 1, 4},   // R4 read
    '{0,1,1,0,8'h00, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 1, 10},  // R10 count 0
    '{0,1,1,0,8'h00, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 1, 7},
    '{0,1,1,0,8'hFF, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 1, 7},
    '{0,1,1,0,8'h01, 0,8'h00,0, 1,24'h00FF01, 0,8'h00,0, 1, 7},
    '{0,1,1,0,8'h5C, 0,8'h00,0, 0,24'h0, 1,8'h5C,0, 0, 10},  // R10 single byte
    '{0,1,1,0,8'h01, 1,8'h01,0, 0,24'h0, 0,8'h00,0, 1, 12},  // R12
    '{0,1,1,0,8'h02, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 1, 12},
    '{1,1,1,0,8'h99, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 0, 11},  // R11 sync wins
    '{0,1,1,0,8'h02, 1,8'h02,0, 0,24'h0, 0,8'h00,0, 1, 11},  // R11 back at command
    '{0,1,1,0,8'h01, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 1, 6},   // count 1
    '{0,1,1,0,8'hAB, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 1, 7},
    '{0,1,1,0,8'hCD, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 1, 7},
    '{0,1,1,0,8'hEF, 0,8'h00,0, 1,24'hABCDEF, 0,8'h00,0, 1, 7},
    '{0,1,0,1,8'h11, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 1, 2},   // R2 nack keeps count
    '{0,1,1,1,8'h3C, 0,8'h00,0, 0,24'h0, 1,8'h3C,1, 0, 9}    // R9 count 1
  };

  task automatic chk_idle(input string tag);
    checks++;
    if (expect_data_o !== 1'b0 || cmd_valid_o !== 1'b0 || addr_valid_o !== 1'b0 || dat_valid_o !== 1'b0) begin
      fails++;
      $display("FAIL %s: got exp=%b cv=%b av=%b dv=%b, expected all 0", tag,
               expect_data_o, cmd_valid_o, addr_valid_o, dat_valid_o);
    end
  endtask

  task automatic apply(input vec_t t);
    sync_rst_i  = t.sy;
    frm_valid_i = t.v;
    frm_ack_i   = t.ak;
    frm_dir_i   = t.dr;
    frm_byte_i  = t.b;
    @(posedge clk);
    @(negedge clk);
    sync_rst_i  = 1'b0;
    frm_valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after release");

    for (int i = 0; i < NV; i++) begin
      logic bad;
      apply(VEC[i]);
      checks++;
      bad = (cmd_valid_o !== VEC[i].ecv) || (cmd_unknown_o !== VEC[i].eunk) ||
            (VEC[i].ecv && cmd_code_o !== VEC[i].ecc) ||
            (addr_valid_o !== VEC[i].eav) || (VEC[i].eav && addr_o !== VEC[i].ea) ||
            (dat_valid_o !== VEC[i].edv) ||
            (VEC[i].edv && (dat_byte_o !== VEC[i].edb || dat_dir_o !== VEC[i].edd)) ||
            (expect_data_o !== VEC[i].eexp);
      if (bad) begin
        fails++;
        $display("FAIL R%0d vec %0d: got cv=%b cc=%h unk=%b av=%b a=%h dv=%b d=%h dir=%b exp=%b; expected cv=%b cc=%h unk=%b av=%b a=%h dv=%b d=%h dir=%b exp=%b",
                 VEC[i].rq, i, cmd_valid_o, cmd_code_o, cmd_unknown_o, addr_valid_o, addr_o,
                 dat_valid_o, dat_byte_o, dat_dir_o, expect_data_o,
                 VEC[i].ecv, VEC[i].ecc, VEC[i].eunk, VEC[i].eav, VEC[i].ea,
                 VEC[i].edv, VEC[i].edb, VEC[i].edd, VEC[i].eexp);
      end
    end

    // R1: reset in the middle of a transfer
    apply('{0,1,1,0,8'h02, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 1, 1});
    apply('{0,1,1,0,8'h04, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 1, 1});
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R1 mid-transfer reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R5: unknown code 0x03 just above the known range, parser stays put
    apply('{0,1,1,0,8'h03, 0,8'h00,0, 0,24'h0, 0,8'h00,0, 0, 5});
    checks++;
    if (cmd_valid_o !== 1'b1 || cmd_unknown_o !== 1'b1 || expect_data_o !== 1'b0) begin
      fails++;
      $display("FAIL R5 code 03: got cv=%b unk=%b exp=%b, expected 1 1 0",
               cmd_valid_o, cmd_unknown_o, expect_data_o);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule